// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits beside a small processor core and turns five interrupt lines into a single request with a fixed target. One line is non-maskable and has the highest rank, three are maskable restart lines (named R75, R65 and R55 here, ranked in that order), and one is a general line whose target comes from an instruction that the core fetches from outside during acknowledge. All five pass through a two-flop synchronizer. The controller then applies the global enable and the per-line masks and resolves a fixed priority.

The core pulses `sample_en` in the clocks where it is allowed to take an interrupt (the next-to-last clock of an instruction, and every clock while halted or holding the bus). It pulses `ack` when it accepts the request. Two register ports model the mask instructions: a write port that sets masks and clears the R75 edge latch, and a read port that reports pending lines, the enable flag and the masks. The non-maskable line keeps a copy of the enable flag, and the next status read returns that copy.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several eligible sources are pending at a sample, the request names the highest-ranked one: non-maskable line first, then R75, R65, R55, and the general line last.
- R2: `req_vec` gives 0x24 for the non-maskable line, 0x3C for R75, 0x34 for R65 and 0x2C for R55. For the general line `req_ext` is 1 and `req_vec` is 0x00.
- R3: R55 and R65 are level inputs. Each requests only while high, unmasked and enabled. A high level shows in the read port pending bits whether or not the line is masked.
- R4: A rising edge on R75 sets an internal latch even while R75 is masked. The latch shows in read bit 7 and requests once it is unmasked and enabled.
- R5: The R75 latch clears when its request is acknowledged, when the write port is written with bit 4 = 1, and on reset.
- R6: Write port layout: bit 3 = 1 loads the masks from bits 2 (R75), 1 (R65) and 0 (R55), where a 1 masks the line. When bit 3 = 0 the masks keep their value.
- R7: Read port layout: bits 7/6/5 = pending R75/R65/R55, bit 4 = enable flag, bit 3 = 0, bits 2/1/0 = masks R75/R65/R55.
- R8: The non-maskable line ignores the masks and the enable. It requests after a rising edge only while it stays high. If it falls before being sampled, no request is made. After an acknowledge it does not request again until it has gone low and then high.
- R9: Acknowledging any request clears the enable, and only `ei_set` sets it again. Reset clears the enable and sets all three masks (read port reads 0x07 with all inputs low).
- R10: An acknowledge of the non-maskable line saves the prior enable. Read bit 4 shows the saved value until the first `mask_rd` strobe. After that it shows the live enable.
- R11: The request output changes only on a clock with `sample_en` high, or on an acknowledge, which drops it.
- R12: A level input that rises with `sample_en` held high raises `req` on the third rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable interrupt line |
| r75_in | input | 1 | Edge-triggered restart line, highest maskable |
| r65_in | input | 1 | Level restart line |
| r55_in | input | 1 | Level restart line, lowest maskable |
| gen_in | input | 1 | General interrupt line, externally supplied target |
| sample_en | input | 1 | Core permits interrupt sampling this clock |
| ack | input | 1 | Core accepts the current request |
| ei_set | input | 1 | Enable-interrupts instruction executed |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| mask_rd | input | 1 | Mask read strobe; ends the saved-enable view |
| mask_rdata | output | 8 | Mask read data |
| req | output | 1 | Interrupt request to the core |
| req_ext | output | 1 | Request is the general line |
| req_vec | output | 8 | Restart target for the current request |

## Verification
A level input that changes just after a clock edge passes two synchronizer edges, and `req` follows on the third edge. The R75 latch and the non-maskable qualifier are set on the third edge, so their requests appear on the fourth. Read port pending bits follow the synchronized inputs after two edges. Writes, enable changes and acknowledges act on the next edge. The bench drives on falling edges and checks exact cycles for the latency requirement. Elsewhere it waits five cycles, past the latest due edge, before sampling. Checks on the read port sample the combinational output while the strobe is high and again after the edge that consumes it.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 5;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_GEN  = 3'd1,
        SRC_R55  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R75  = 3'd4,
        SRC_NMI  = 3'd5
    } irq_src_e;

    localparam logic [7:0] VEC_NMI = 8'h24;
    localparam logic [7:0] VEC_R55 = 8'h2C;
    localparam logic [7:0] VEC_R65 = 8'h34;
    localparam logic [7:0] VEC_R75 = 8'h3C;

    typedef struct packed {
        logic       nmi_prev;
        logic       r75_prev;
        logic       nmi_armed;
        logic       r75_lat;
        logic       ie;
        logic       ie_saved;
        logic       saved_view;
        logic [2:0] mask;
        logic       req;
        irq_src_e   src;
    } ctrl_state_t;

    function automatic logic [7:0] vec_of(irq_src_e s);
        case (s)
            SRC_NMI: vec_of = VEC_NMI;
            SRC_R75: vec_of = VEC_R75;
            SRC_R65: vec_of = VEC_R65;
            SRC_R55: vec_of = VEC_R55;
            default: vec_of = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] elig,
    output irq_src_e     win
);
    always_comb begin
        win = SRC_NONE;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) win = irq_src_e'(3'(i + 1));
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_in,
    input  logic       r75_in,
    input  logic       r65_in,
    input  logic       r55_in,
    input  logic       gen_in,
    input  logic       sample_en,
    input  logic       ack,
    input  logic       ei_set,
    input  logic       mask_wr,
    input  logic [7:0] mask_wdata,
    input  logic       mask_rd,
    output logic [7:0] mask_rdata,
    output logic       req,
    output logic       req_ext,
    output logic [7:0] req_vec
);
    localparam int MW = 3;

    logic [NUM_SRC-1:0] raw, syn, elig;
    irq_src_e    win;
    ctrl_state_t st_d, st_q;
    logic        r75_rise, nmi_rise, wdata_unused;

    assign raw = {nmi_in, r75_in, r65_in, r55_in, gen_in};
    assign wdata_unused = ^mask_wdata[7:5];

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign elig[4] = st_q.nmi_armed & syn[4];
    assign elig[3] = st_q.r75_lat & ~st_q.mask[2] & st_q.ie;
    assign elig[2] = syn[2] & ~st_q.mask[1] & st_q.ie;
    assign elig[1] = syn[1] & ~st_q.mask[0] & st_q.ie;
    assign elig[0] = syn[0] & st_q.ie;

    irq_arb #(.N(NUM_SRC)) u_arb (.elig(elig), .win(win));

    assign r75_rise = syn[3] & ~st_q.r75_prev;
    assign nmi_rise = syn[4] & ~st_q.nmi_prev;

    always_comb begin
        st_d = st_q;
        st_d.r75_prev = syn[3];
        st_d.nmi_prev = syn[4];

        if (!syn[4])      st_d.nmi_armed = 1'b0;
        else if (nmi_rise) st_d.nmi_armed = 1'b1;

        if (mask_wr) begin
            if (mask_wdata[3]) st_d.mask = mask_wdata[MW-1:0];
            if (mask_wdata[4]) st_d.r75_lat = 1'b0;
        end
        if (ei_set)  st_d.ie = 1'b1;
        if (mask_rd) st_d.saved_view = 1'b0;

        if (sample_en) begin
            st_d.req = (win != SRC_NONE);
            st_d.src = win;
        end

        if (ack && st_q.req) begin
            st_d.req = 1'b0;
            st_d.src = SRC_NONE;
            st_d.ie  = 1'b0;
            case (st_q.src)
                SRC_NMI: begin
                    st_d.nmi_armed  = 1'b0;
                    st_d.ie_saved   = st_q.ie;
                    st_d.saved_view = 1'b1;
                end
                SRC_R75: st_d.r75_lat = 1'b0;
                default: ;
            endcase
        end

        if (r75_rise) st_d.r75_lat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
            st_q.src  <= SRC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req        = st_q.req;
    assign req_ext    = st_q.req && (st_q.src == SRC_GEN);
    assign req_vec    = vec_of(st_q.src);
    assign mask_rdata = {st_q.r75_lat, syn[2], syn[1],
                         st_q.saved_view ? st_q.ie_saved : st_q.ie,
                         1'b0, st_q.mask};
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       req_ext,
    input logic [7:0] req_vec,
    input logic       ack,
    input logic       sample_en,
    input logic       mask_wr,
    input logic [7:0] mask_wdata,
    input logic       ie,
    input logic [2:0] mask,
    input logic       r75_lat,
    input logic       r75_syn
);
    assert_vec_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_ext) |-> (req_vec == 8'h24 || req_vec == 8'h2C ||
                               req_vec == 8'h34 || req_vec == 8'h3C));

    assert_ext_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ext |-> (req && req_vec == 8'h00));

    assert_ack_clears_ie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> !ie);

    assert_enable_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req) && req_vec != 8'h24) |-> $past(ie));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !mask_wdata[3]) |=> $stable(mask));

    assert_latch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata[4] && !r75_syn) |=> !r75_lat);

    assert_sample_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !(ack && req)) |=> $stable(req));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ext(req_ext), .req_vec(req_vec),
    .ack(ack), .sample_en(sample_en), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ie(st_q.ie), .mask(st_q.mask), .r75_lat(st_q.r75_lat), .r75_syn(syn[3])
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_in = 0, r75_in = 0, r65_in = 0, r55_in = 0, gen_in = 0;
    logic sample_en = 1, ack = 0, ei_set = 0, mask_wr = 0, mask_rd = 0;
    logic [7:0] mask_wdata = 8'h00;
    logic [7:0] mask_rdata, req_vec;
    logic req, req_ext;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .r75_in(r75_in),
        .r65_in(r65_in), .r55_in(r55_in), .gen_in(gen_in),
        .sample_en(sample_en), .ack(ack), .ei_set(ei_set),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rd(mask_rd),
        .mask_rdata(mask_rdata), .req(req), .req_ext(req_ext), .req_vec(req_vec)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {nmi_in, r75_in, r65_in, r55_in, gen_in} = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic do_ei();
        ei_set = 1'b1; tick(1); ei_set = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_wr = 1'b1; mask_wdata = v; tick(1); mask_wr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 reset req", {7'd0, req}, 8'd0);
        chk("R9 reset read", mask_rdata, 8'h07);
        r75_in = 1; tick(2); r75_in = 0; tick(5);
        chk("R4 latch while masked", {7'd0, mask_rdata[7]}, 8'd1);
        do_reset();
        chk("R5 reset clears latch", mask_rdata, 8'h07);
    endtask

    task automatic t_levels();
        do_reset();
        do_ei();
        r55_in = 1; tick(5);
        chk("R3 masked level no req", {7'd0, req}, 8'd0);
        chk("R7 read layout pending", mask_rdata, 8'h37);
        wr_mask(8'h00);
        chk("R6 no bit3 keeps masks", {5'd0, mask_rdata[2:0]}, 8'h07);
        wr_mask(8'h08); tick(3);
        chk("R3 unmasked level req", {7'd0, req}, 8'd1);
        chk("R2 r55 vector", req_vec, 8'h2C);
        do_ack(); r55_in = 0; tick(5);
        chk("R9 ack clears enable", mask_rdata, 8'h00);
    endtask

    task automatic t_sample_gate();
        do_reset(); wr_mask(8'h08); do_ei();
        sample_en = 0; r65_in = 1; tick(5);
        chk("R11 no sample no req", {7'd0, req}, 8'd0);
        sample_en = 1; tick(1);
        chk("R11 sample raises req", {7'd0, req}, 8'd1);
        chk("R2 r65 vector", req_vec, 8'h34);
        do_ack(); r65_in = 0; tick(3);
    endtask

    task automatic t_latency();
        do_reset(); wr_mask(8'h08); do_ei();
        r55_in = 1; tick(2);
        chk("R12 not before third edge", {7'd0, req}, 8'd0);
        tick(1);
        chk("R12 third edge req", {7'd0, req}, 8'd1);
        do_ack(); r55_in = 0; tick(3);
    endtask

    task automatic t_r75();
        do_reset(); wr_mask(8'h0C); do_ei();
        r75_in = 1; tick(2); r75_in = 0; tick(5);
        chk("R4 masked edge no req", {7'd0, req}, 8'd0);
        chk("R4 latch pending bit7", {7'd0, mask_rdata[7]}, 8'd1);
        wr_mask(8'h08); tick(3);
        chk("R4 unmask requests", req_vec, 8'h3C);
        do_ack(); tick(2);
        chk("R5 service clears latch", {7'd0, mask_rdata[7]}, 8'd0);
        do_ei(); wr_mask(8'h0C);
        r75_in = 1; tick(2); r75_in = 0; tick(5);
        wr_mask(8'h1C); tick(1);
        chk("R5 write bit4 clears latch", {7'd0, mask_rdata[7]}, 8'd0);
        wr_mask(8'h08); tick(5);
        chk("R5 cleared latch no req", {7'd0, req}, 8'd0);
    endtask

    task automatic t_priority();
        do_reset(); wr_mask(8'h08); do_ei();
        {nmi_in, r75_in, r65_in, r55_in, gen_in} = '1; tick(6);
        chk("R1 nmi first", req_vec, 8'h24);
        do_ack(); do_ei(); tick(3);
        chk("R1 r75 second", req_vec, 8'h3C);
        do_ack(); do_ei(); tick(3);
        chk("R1 r65 third", req_vec, 8'h34);
        do_ack(); r65_in = 0; do_ei(); tick(3);
        chk("R1 r55 fourth", req_vec, 8'h2C);
        do_ack(); r55_in = 0; do_ei(); tick(3);
        chk("R2 general line ext", {6'd0, req, req_ext}, 8'd3);
        chk("R2 general line vec", req_vec, 8'h00);
        do_ack();
        {nmi_in, r75_in, gen_in} = '0; tick(3);
    endtask

    task automatic t_nmi();
        do_reset();
        nmi_in = 1; tick(5);
        chk("R8 ignores enable and masks", req_vec, 8'h24);
        do_ack(); tick(5);
        chk("R8 no re-request while high", {7'd0, req}, 8'd0);
        nmi_in = 0; tick(3); nmi_in = 1; tick(5);
        chk("R8 new edge requests", {7'd0, req}, 8'd1);
        do_ack(); nmi_in = 0; tick(3);
        sample_en = 0; nmi_in = 1; tick(5); nmi_in = 0; tick(5);
        sample_en = 1; tick(2);
        chk("R8 dropped before sample", {7'd0, req}, 8'd0);
        do_ei();
        nmi_in = 1; tick(5);
        do_ack(); nmi_in = 0; tick(1);
        mask_rd = 1;
        chk("R10 saved enable shown", {7'd0, mask_rdata[4]}, 8'd1);
        tick(1); mask_rd = 0;
        chk("R10 live enable after read", {7'd0, mask_rdata[4]}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_levels();
        t_sample_gate();
        t_latency();
        t_r75();
        t_priority();
        t_nmi();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule